// File: doc/BRIEF.md
# Switching and timeout clock generator

This block produces two timing strobes from one system clock. The first is a clock-enable for a switching output stage. It is taken either from a divider that runs at system-clock rate, with one of eight fixed ratios, or from an external low-frequency oscillator. The oscillator's rising edges are brought into the system clock domain and turned into single-cycle enables. A single source bit selects between the two.

The second strobe is a slow timeout tick, used by debounce and volume-ramp timeout logic. It has its own enable and a choice of two periods, both powers of two of the system clock. Both exponents are parameters, so short periods can be used outside the default build. The register fields arrive as plain inputs. Their register defaults are divide code `111`, source bit 0, timeout enable 0 and rate bit 0. The divider's internal active ratio also resets to 16.

Top module: `switch_timeout_clkgen`

## Requirements
- R1: With `src_osc_i` = 0, `sw_en_o` is a one-cycle pulse repeating every N system clock cycles. N is set by `div_code_i` as follows: 000→1, 001→2, 010→3, 011→4, 100→6, 101→8, 110→12, 111→16.
- R2: In reset `sw_en_o` is low, and the active ratio is 16. The first divider pulse after reset release is raised by the 15th rising clock edge after release, whatever the value of `div_code_i`.
- R3: A ratio of 1 holds `sw_en_o` high on every cycle for as long as the code stays 000.
- R4: A change of `div_code_i` is applied only at the end of a pulse cycle. A period that is already running keeps its old length, and the next period has the new length.
- R5: With `src_osc_i` = 1, `sw_en_o` gives exactly one single-cycle pulse for each rising edge of `osc_i`, and no divider pulses appear.
- R6: With `src_osc_i` = 0, edges on `osc_i` have no effect on the spacing of `sw_en_o`.
- R7: `tmo_tick_o` is never high while `tmo_en_i` is 0, and it is low in reset.
- R8: While enabled, `tmo_tick_o` is a one-cycle pulse with a period of 2^TMO_SLOW_EXP cycles when `tmo_fast_i` = 0, and 2^TMO_FAST_EXP cycles when `tmo_fast_i` = 1.
- R9: The timeout counter is cleared while `tmo_en_i` is 0. After enable, the first tick therefore appears on the clock cycle whose count, from the first cycle that samples the enable high as cycle 0, equals period−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| osc_i | input | 1 | Low-frequency oscillator clock, asynchronous |
| div_code_i | input | 3 | Divide ratio code |
| src_osc_i | input | 1 | Switching source: 0 divider, 1 oscillator |
| tmo_en_i | input | 1 | Timeout tick enable |
| tmo_fast_i | input | 1 | Timeout rate: 0 long period, 1 short period |
| sw_en_o | output | 1 | Switching clock-enable pulse |
| tmo_tick_o | output | 1 | Timeout tick pulse |

## Verification
The hardest case to reach from the ports is a ratio change that lands partway through a running period. It can only be seen by timing the change against pulses the bench has already observed. The bench first locks onto a divider pulse, applies one random code at that pulse, and then applies a second random code a random number of cycles into the period that follows. It expects the first interval at the first code's ratio and the next at the second's. Oscillator edges are toggled at random during these divider runs, which also covers R6. The timeout tick is built with small exponents so that both rates and several enable/disable cycles fit in a short run.

// File: rtl/stc_pkg.sv
package stc_pkg;
   localparam int unsigned DIV_CODE_W = 3;
   localparam int unsigned DIV_MAX    = 16;
   localparam int unsigned DIV_CNT_W  = $clog2(DIV_MAX);

   typedef logic [DIV_CODE_W-1:0] div_code_t;
   typedef logic [DIV_CNT_W-1:0]  div_cnt_t;

   localparam div_code_t DIV_CODE_RST = 3'b111;

   // Terminal count (ratio - 1) for each divide code.
   function automatic div_cnt_t div_terminal(input div_code_t code);
      int unsigned r;
      case (code)
         3'd0:    r = 1;
         3'd1:    r = 2;
         3'd2:    r = 3;
         3'd3:    r = 4;
         3'd4:    r = 6;
         3'd5:    r = 8;
         3'd6:    r = 12;
         default: r = 16;
      endcase
      return div_cnt_t'(r - 1);
   endfunction
endpackage

// File: rtl/stc_ratio_div.sv
module stc_ratio_div
   import stc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  div_code_t code_i,
   output logic      pulse_o
);
   div_cnt_t cnt_q;
   div_cnt_t term_q;
   logic     wrap;

   assign wrap = (cnt_q == term_q);

   // The ratio is reloaded only when a period ends.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         term_q <= div_terminal(DIV_CODE_RST);
      end else if (wrap) begin
         cnt_q  <= '0;
         term_q <= div_terminal(code_i);
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign pulse_o = wrap;
endmodule

// File: rtl/stc_osc_edge.sv
module stc_osc_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic osc_i,
   output logic rise_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("stc_osc_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Stages 0..SYNC_STAGES-1 synchronise; the last one holds history.
   logic [SYNC_STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[0] <= 1'b0;
      else         sh_q[0] <= osc_i;
   end

   for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sh_q[i] <= 1'b0;
         else         sh_q[i] <= sh_q[i-1];
      end
   end

   assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/stc_timeout_tick.sv
module stc_timeout_tick #(
   parameter int unsigned SLOW_EXP = 21,
   parameter int unsigned FAST_EXP = 19
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic fast_i,
   output logic tick_o
);
   generate
      if (FAST_EXP < 1) begin : g_bad_fast
         $error("stc_timeout_tick: FAST_EXP must be at least 1");
      end
      if (FAST_EXP >= SLOW_EXP) begin : g_bad_order
         $error("stc_timeout_tick: FAST_EXP must be below SLOW_EXP");
      end
   endgenerate

   logic [SLOW_EXP-1:0] cnt_q;
   logic                full_slow;
   logic                full_fast;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (!en_i) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   // The short period reuses the low bits of the same counter.
   assign full_slow = &cnt_q;
   assign full_fast = &cnt_q[FAST_EXP-1:0];
   assign tick_o    = en_i & (fast_i ? full_fast : full_slow);
endmodule

// File: rtl/switch_timeout_clkgen.sv
module switch_timeout_clkgen
   import stc_pkg::*;
#(
   parameter int unsigned TMO_SLOW_EXP = 21,
   parameter int unsigned TMO_FAST_EXP = 19,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       osc_i,
   input  logic [2:0] div_code_i,
   input  logic       src_osc_i,
   input  logic       tmo_en_i,
   input  logic       tmo_fast_i,
   output logic       sw_en_o,
   output logic       tmo_tick_o
);
   logic div_pulse;
   logic osc_pulse;

   stc_ratio_div u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .code_i  (div_code_i),
      .pulse_o (div_pulse)
   );

   stc_osc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_osc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .osc_i  (osc_i),
      .rise_o (osc_pulse)
   );

   stc_timeout_tick #(.SLOW_EXP(TMO_SLOW_EXP), .FAST_EXP(TMO_FAST_EXP)) u_tmo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (tmo_en_i),
      .fast_i (tmo_fast_i),
      .tick_o (tmo_tick_o)
   );

   assign sw_en_o = src_osc_i ? osc_pulse : div_pulse;
endmodule

// File: rtl/stc_clkgen_chk.sv
module stc_clkgen_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] div_code_i,
   input logic       src_osc_i,
   input logic       tmo_en_i,
   input logic       sw_en_o,
   input logic       tmo_tick_o
);
   // R3: a wrap taken under code 000 starts a ratio-1 period
   a_r3_unit_ratio_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_osc_i && $past(!src_osc_i) && $past(div_code_i) == 3'd0 && $past(sw_en_o))
      |-> sw_en_o);

   // R1: any ratio above 1 leaves a gap after each pulse
   a_r1_gap_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_osc_i && $past(!src_osc_i) && $past(div_code_i) != 3'd0 && $past(sw_en_o))
      |-> !sw_en_o);

   // R5: oscillator enables last one cycle
   a_r5_osc_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_osc_i && sw_en_o) |=> !(src_osc_i && sw_en_o));

   // R7: no tick while disabled
   a_r7_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tmo_en_i |-> !tmo_tick_o);

   // R8: ticks are single-cycle
   a_r8_tick_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tmo_tick_o |=> !tmo_tick_o);
endmodule

bind switch_timeout_clkgen stc_clkgen_chk chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .div_code_i (div_code_i),
   .src_osc_i  (src_osc_i),
   .tmo_en_i   (tmo_en_i),
   .sw_en_o    (sw_en_o),
   .tmo_tick_o (tmo_tick_o)
);

// File: tb/switch_timeout_clkgen_tb_top.sv
`timescale 1ns/1ps
module switch_timeout_clkgen_tb_top;
   localparam int unsigned SLOW_EXP = 6;
   localparam int unsigned FAST_EXP = 4;
   localparam int SLOW_P = 1 << SLOW_EXP;
   localparam int FAST_P = 1 << FAST_EXP;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       osc_i = 1'b0;
   logic [2:0] div_code_i = 3'd0;
   logic       src_osc_i = 1'b0;
   logic       tmo_en_i = 1'b0;
   logic       tmo_fast_i = 1'b0;
   logic       sw_en_o;
   logic       tmo_tick_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   switch_timeout_clkgen #(.TMO_SLOW_EXP(SLOW_EXP), .TMO_FAST_EXP(FAST_EXP)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .osc_i      (osc_i),
      .div_code_i (div_code_i),
      .src_osc_i  (src_osc_i),
      .tmo_en_i   (tmo_en_i),
      .tmo_fast_i (tmo_fast_i),
      .sw_en_o    (sw_en_o),
      .tmo_tick_o (tmo_tick_o)
   );

   function automatic int ratio_of(input logic [2:0] c);
      case (c)
         3'd0: return 1;
         3'd1: return 2;
         3'd2: return 3;
         3'd3: return 4;
         3'd4: return 6;
         3'd5: return 8;
         3'd6: return 12;
         default: return 16;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts negedges until sw_en_o is seen high; optionally jitters osc_i.
   task automatic wait_sw(input bit jitter, output int n);
      n = 0;
      do begin
         @(negedge clk);
         if (jitter) osc_i = 1'($urandom % 2);
         n++;
      end while (!sw_en_o);
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tmo_tick_o);
   endtask

   // R1, R4, R6: a code at a pulse, a second code mid-period
   task automatic div_rounds(input int iters);
      int n;
      int a;
      int m;
      logic [2:0] c1;
      logic [2:0] c2;
      wait_sw(1'b1, n);
      for (int i = 0; i < iters; i++) begin
         c1 = (i < 4) ? 3'(i * 2 + 1) : 3'($urandom % 8);
         c2 = 3'($urandom % 8);
         div_code_i = c1;
         a = ratio_of(c1);
         if (a >= 2) begin
            m = 1 + int'($urandom % (a - 1));
            n = 0;
            do begin
               @(negedge clk);
               osc_i = 1'($urandom % 2);
               n++;
               if (n == m) div_code_i = c2;
            end while (!sw_en_o);
            chk("R4 period kept after mid-period code change", n, a);
            wait_sw(1'b1, n);
            chk("R1/R6 ratio of new code", n, ratio_of(c2));
         end else begin
            wait_sw(1'b1, n);
            chk("R1 ratio 1", n, 1);
         end
      end
   endtask

   // R5: count oscillator enables against rising edges
   task automatic osc_round(input int edges, input int half);
      int seen;
      int prev;
      int dbl;
      src_osc_i = 1'b1;
      osc_i = 1'b0;
      repeat (6) @(negedge clk);
      seen = 0; prev = 0; dbl = 0;
      for (int e = 0; e < edges * 2 + 3; e++) begin
         osc_i = (e < edges * 2) ? 1'(~e[0]) : 1'b0;
         repeat (half) begin
            @(negedge clk);
            if (sw_en_o) seen++;
            if (sw_en_o && prev != 0) dbl++;
            prev = int'(sw_en_o);
         end
      end
      chk("R5 one enable per oscillator rising edge", seen, edges);
      chk("R5 enables are single-cycle", dbl, 0);
   endtask

   task automatic tmo_round(input bit fast, input int off_cycles);
      int n;
      int p;
      int t;
      p = fast ? FAST_P : SLOW_P;
      tmo_en_i = 1'b0;
      t = 0;
      repeat (off_cycles) begin
         @(negedge clk);
         if (tmo_tick_o) t++;
      end
      chk("R7 no tick while disabled", t, 0);
      tmo_fast_i = fast;
      tmo_en_i = 1'b1;
      wait_tick(n);
      chk("R9 first tick after enable", n, p - 1);
      wait_tick(n);
      chk("R8 tick period", n, p);
      wait_tick(n);
      chk("R8 tick period repeat", n, p);
      // leave it mid-count before the next disable
      repeat (1 + ($urandom % (p - 1))) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n;
      int hi;
      void'($urandom(32'd20240611));
      // reset with code 000 applied: the reset ratio 16 must still govern
      repeat (4) @(negedge clk);
      chk("R2 switching enable low in reset", int'(sw_en_o), 0);
      chk("R7 tick low in reset", int'(tmo_tick_o), 0);
      rst_ni = 1'b1;
      wait_sw(1'b0, n);
      chk("R2 first pulse uses reset ratio 16", n, 15);
      hi = 0;
      repeat (6) begin
         @(negedge clk);
         if (sw_en_o) hi++;
      end
      chk("R3 ratio 1 holds enable high", hi, 6);

      div_rounds(24);
      for (int r = 0; r < 3; r++) osc_round(3 + int'($urandom % 6), 2 + int'($urandom % 4));
      src_osc_i = 1'b0;
      div_rounds(6);

      tmo_round(1'b0, 40);
      tmo_round(1'b1, 40);
      for (int r = 0; r < 4; r++) tmo_round(1'($urandom % 2), 5 + int'($urandom % 30));

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule